// File: doc/BRIEF.md
# Four-Port Arbitrated Shared Data Memory

This block is a data memory tile that several neighbouring processors reach directly. Up to four request ports share one single-ported word store. Each cycle a ranking-based arbiter picks at most one requesting port, and that port performs exactly one read or one write. A port that loses keeps its request raised and is served in a later cycle. Read data comes back on a shared data bus one cycle after the grant, with a valid bit raised only for the port that was served.

Each port has its own address generator, so a processor can stream through a buffer without sending an address on every request. The generator can pass the request address through unchanged. It can also walk a pointer by a programmable stride, or walk it around a circular window between a start and an end address. Software loads each port's mode, start, stride and end through a write-only configuration strobe before streaming. The port ranking comes from a separate ranking register. With a 13-bit address parameter the store holds 8192 words of 16 bits, which is 16 KB.

Top module: `shmem_arb_tile`

## Requirements
- R1: The tile has NP = 4 request ports. Each port has its own `req`, `we`, address slice `addr[p*AW +: AW]` and write data slice `wdata[p*DW +: DW]`. The store holds 2**AW words of DW = 16 bits (AW = 13 gives 8192 words).
- R2: Outside reset, `gnt` has at most one bit set, and a bit is set only for a port whose `req` is high. Whenever any `req` is high, some port is granted in that same cycle.
- R3: A granted port with `we` = 1 writes its data to its generated address at the clock edge that ends the grant cycle. A granted port with `we` = 0 reads from its generated address. A port that is not granted changes nothing in the store.
- R4: The ranking register holds four 2-bit port numbers. Entry k sits in `prio_rank[2k+1:2k]`, and entry 0 has the highest rank. The granted port is the requesting port listed in the lowest entry. The register loads from `prio_rank` on a cycle with `prio_we` = 1 and is used from the next cycle. After reset it holds 0,1,2,3, so port 0 has the highest rank.
- R5: One cycle after a granted read, `rdata` holds the word read and `rvalid` has exactly the bit of that port set. In every other cycle, including the cycle after a write, `rvalid` is zero.
- R6: Mode encoding: 0 = direct, where the port's `addr` slice is the address; 1 = stride; 2 = circular; 3 = behaves as direct.
- R7: A port's address pointer changes only on a cycle in which that port is granted, or on a configuration load for that port. A port that is kept waiting keeps its pointer.
- R8: In stride mode the access uses the pointer. After the grant the pointer becomes pointer + stride, modulo 2**AW.
- R9: In circular mode the access uses the pointer. After the grant the pointer becomes the start address if the pointer was greater than or equal to the end address. Otherwise it becomes pointer + stride.
- R10: On a cycle with `cfg_we` = 1, port `cfg_port` loads `cfg_mode`, `cfg_base`, `cfg_stride` and `cfg_end`, and its pointer is set to `cfg_base`. The new settings apply from the next cycle.
- R11: While `rst` is high, `gnt` and `rvalid` are zero. After reset, every port is in direct mode with its pointer at 0, and the ranking is 0,1,2,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NP | Per-port access request, held until granted |
| we | input | NP | Per-port write (1) or read (0) |
| addr | input | NP*AW | Per-port address, used in direct mode |
| wdata | input | NP*DW | Per-port write data |
| gnt | output | NP | One-hot grant for this cycle |
| rvalid | output | NP | Per-port read data valid, one cycle after a granted read |
| rdata | output | DW | Shared read data bus |
| cfg_we | input | 1 | Load strobe for one port's generator settings |
| cfg_port | input | 2 | Port whose settings are loaded |
| cfg_mode | input | 2 | Addressing mode |
| cfg_base | input | AW | Start address; also the initial pointer |
| cfg_stride | input | AW | Pointer step |
| cfg_end | input | AW | Last address of the circular window |
| prio_we | input | 1 | Load strobe for the ranking register |
| prio_rank | input | 2*NP | Four 2-bit port numbers, entry 0 highest |

## Verification
The assertions check the per-cycle rules on every cycle:
- the grant is one-hot or empty, goes only to a requester, and is given whenever there is a request;
- the top-ranked requester always wins;
- `rvalid` follows the previous cycle's granted reads;
- a waiting port's pointer holds;
- a configuration load sets the pointer to its start address;
- a circular pointer wraps to its start.

Only the bench scenarios can show that data lands at, and returns from, the right addresses. The same goes for the whole grant sequence under each of four rankings, for stride wrap-around at the top of the address space, and for circular overshoot past the end address.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    localparam int NPORTS = 4;
    localparam int PIDX_W = $clog2(NPORTS);

    typedef enum logic [1:0] {
        AG_DIRECT = 2'd0,
        AG_STRIDE = 2'd1,
        AG_CIRC   = 2'd2,
        AG_ALT    = 2'd3
    } ag_mode_e;

    typedef struct packed {
        logic              vld;
        logic [PIDX_W-1:0] idx;
    } win_t;

    function automatic logic mode_uses_ptr(input ag_mode_e m);
        return (m == AG_STRIDE) || (m == AG_CIRC);
    endfunction

endpackage

// File: rtl/shmem_prio_arb.sv
module shmem_prio_arb
    import shmem_pkg::*;
#(
    parameter int NP = NPORTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        req,
    input  logic                 rank_we,
    input  logic [NP*PIDX_W-1:0] rank_in,
    output logic [NP-1:0]        gnt,
    output win_t                 win
);

    logic [PIDX_W-1:0] rank_q [NP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NP; k++) rank_q[k] <= PIDX_W'(k);
        end else if (rank_we) begin
            for (int k = 0; k < NP; k++) rank_q[k] <= rank_in[k*PIDX_W +: PIDX_W];
        end
    end

    always_comb begin
        win = '0;
        for (int k = NP-1; k >= 0; k--) begin
            if (req[rank_q[k]]) begin
                win.vld = 1'b1;
                win.idx = rank_q[k];
            end
        end
        if (rst) win.vld = 1'b0;
        gnt = '0;
        if (win.vld) gnt[win.idx] = 1'b1;
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    p_busy_grants_r2: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));
    p_top_rank_wins_r4: assert property (@(posedge clk) disable iff (rst)
        req[rank_q[0]] |-> gnt[rank_q[0]]);

endmodule

// File: rtl/shmem_addr_gen.sv
module shmem_addr_gen
    import shmem_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  ag_mode_e      cfg_mode,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_stride,
    input  logic [AW-1:0] cfg_end,
    input  logic          grant,
    input  logic [AW-1:0] dir_addr,
    output logic [AW-1:0] acc_addr
);

    ag_mode_e      mode_q;
    logic [AW-1:0] base_q, stride_q, end_q, ptr_q;

    assign acc_addr = mode_uses_ptr(mode_q) ? ptr_q : dir_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= AG_DIRECT;
            base_q   <= '0;
            stride_q <= '0;
            end_q    <= '0;
            ptr_q    <= '0;
        end else if (cfg_load) begin
            mode_q   <= cfg_mode;
            base_q   <= cfg_base;
            stride_q <= cfg_stride;
            end_q    <= cfg_end;
            ptr_q    <= cfg_base;
        end else if (grant) begin
            case (mode_q)
                AG_STRIDE: ptr_q <= ptr_q + stride_q;
                AG_CIRC:   ptr_q <= (ptr_q >= end_q) ? base_q : ptr_q + stride_q;
                default:   ptr_q <= ptr_q;
            endcase
        end
    end

    p_idle_ptr_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!grant && !cfg_load) |=> $stable(ptr_q));
    p_load_sets_ptr_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (ptr_q == $past(cfg_base)));
    p_circ_wraps_r9: assert property (@(posedge clk) disable iff (rst)
        (grant && !cfg_load && mode_q == AG_CIRC && ptr_q >= end_q)
        |=> (ptr_q == $past(base_q)));

endmodule

// File: rtl/shmem_store.sv
module shmem_store #(
    parameter int AW = 11,
    parameter int DW = 16,
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NP-1:0] rd_sel,
    output logic [DW-1:0] rdata,
    output logic [NP-1:0] rvalid
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && wr) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (en && !wr) rdata <= mem[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= '0;
        else     rvalid <= (en && !wr) ? rd_sel : '0;
    end

endmodule

// File: rtl/shmem_arb_tile.sv
module shmem_arb_tile
    import shmem_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 16,
    parameter int NP = NPORTS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NP-1:0]        req,
    input  logic [NP-1:0]        we,
    input  logic [NP*AW-1:0]     addr,
    input  logic [NP*DW-1:0]     wdata,
    output logic [NP-1:0]        gnt,
    output logic [NP-1:0]        rvalid,
    output logic [DW-1:0]        rdata,
    input  logic                 cfg_we,
    input  logic [PIDX_W-1:0]    cfg_port,
    input  logic [1:0]           cfg_mode,
    input  logic [AW-1:0]        cfg_base,
    input  logic [AW-1:0]        cfg_stride,
    input  logic [AW-1:0]        cfg_end,
    input  logic                 prio_we,
    input  logic [NP*PIDX_W-1:0] prio_rank
);

    win_t          win;
    logic [AW-1:0] acc_addr [NP];
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic          sel_we;

    shmem_prio_arb #(.NP(NP)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rank_we (prio_we),
        .rank_in (prio_rank),
        .gnt     (gnt),
        .win     (win)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        shmem_addr_gen #(.AW(AW)) u_ag (
            .clk        (clk),
            .rst        (rst),
            .cfg_load   (cfg_we && (cfg_port == PIDX_W'(p))),
            .cfg_mode   (ag_mode_e'(cfg_mode)),
            .cfg_base   (cfg_base),
            .cfg_stride (cfg_stride),
            .cfg_end    (cfg_end),
            .grant      (gnt[p]),
            .dir_addr   (addr[p*AW +: AW]),
            .acc_addr   (acc_addr[p])
        );
    end

    assign sel_addr  = acc_addr[win.idx];
    assign sel_we    = we[win.idx];
    assign sel_wdata = wdata[win.idx*DW +: DW];

    shmem_store #(.AW(AW), .DW(DW), .NP(NP)) u_store (
        .clk    (clk),
        .rst    (rst),
        .en     (win.vld),
        .wr     (sel_we),
        .addr   (sel_addr),
        .wdata  (sel_wdata),
        .rd_sel (gnt),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    p_rvalid_tracks_read_r5: assert property (@(posedge clk) disable iff (rst)
        rvalid == $past(gnt & ~we));
    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |-> (gnt == '0));

endmodule

// File: tb/shmem_arb_tile_test.sv
module shmem_arb_tile_test;

    localparam int AW = 11;
    localparam int DW = 16;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [NP-1:0]   req, we;
    logic [NP*AW-1:0] addr;
    logic [NP*DW-1:0] wdata;
    logic [NP-1:0]   gnt, rvalid;
    logic [DW-1:0]   rdata;
    logic            cfg_we;
    logic [1:0]      cfg_port, cfg_mode;
    logic [AW-1:0]   cfg_base, cfg_stride, cfg_end;
    logic            prio_we;
    logic [7:0]      prio_rank;

    logic [DW-1:0] refm [0:(1<<AW)-1];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shmem_arb_tile #(.AW(AW), .DW(DW), .NP(NP)) uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .gnt(gnt), .rvalid(rvalid), .rdata(rdata),
        .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_mode(cfg_mode),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_end(cfg_end),
        .prio_we(prio_we), .prio_rank(prio_rank)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_port(input int p, input bit r, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req[p] = r;
        we[p]  = w;
        addr[p*AW +: AW] = a;
        wdata[p*DW +: DW] = d;
    endtask

    // one lone access; expaddr is where the bench expects it to land
    task automatic single(input int p, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [AW-1:0] expaddr, input string tag);
        @(negedge clk);
        set_port(p, 1'b1, w, a, d);
        #1;
        check(gnt == NP'(1 << p), tag, 32'(gnt), 32'(1 << p));
        @(negedge clk);
        req[p] = 1'b0;
        if (w) begin
            refm[expaddr] = d;
            check(rvalid == '0, tag, 32'(rvalid), 0);
        end else begin
            check(rvalid == NP'(1 << p), tag, 32'(rvalid), 32'(1 << p));
            check(rdata == refm[expaddr], tag, 32'(rdata), 32'(refm[expaddr]));
        end
    endtask

    task automatic configure(input int p, input logic [1:0] m, input logic [AW-1:0] b,
                             input logic [AW-1:0] s, input logic [AW-1:0] e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 2'(p); cfg_mode = m;
        cfg_base = b; cfg_stride = s; cfg_end = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_rank(input logic [7:0] r);
        @(negedge clk);
        prio_we = 1'b1; prio_rank = r;
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req = '1; we = '0; addr = '0; wdata = '0;
        cfg_we = 0; cfg_port = 0; cfg_mode = 0; cfg_base = 0; cfg_stride = 0; cfg_end = 0;
        prio_we = 0; prio_rank = 0;
        repeat (3) @(negedge clk);
        check(gnt == '0, "R11 gnt in reset", 32'(gnt), 0);
        check(rvalid == '0, "R11 rvalid in reset", 32'(rvalid), 0);
        rst = 1'b0;
        #1;
        check(gnt == 4'b0001, "R11 R4 default rank", 32'(gnt), 1);
        @(negedge clk);
        req = '0;
    endtask

    task automatic t_direct();
        for (int p = 0; p < NP; p++)
            single(p, 1'b1, AW'(40 + p*100), DW'(16'h1234 + p*16'h1111), AW'(40 + p*100), "R1 R3 R6 direct write");
        for (int p = 0; p < NP; p++)
            single((p+1) % NP, 1'b0, AW'(40 + p*100), 0, AW'(40 + p*100), "R3 R5 direct read");
        for (int p = 0; p < NP; p++)
            single(p, 1'b1, AW'(16 + p), DW'(16'hA000 + p*16'h0111), AW'(16 + p), "R3 preload");
    endtask

    task automatic prio_round(input logic [7:0] r);
        logic [NP-1:0] seen;
        load_rank(r);
        @(negedge clk);
        for (int p = 0; p < NP; p++) set_port(p, 1'b1, 1'b0, AW'(16 + p), 0);
        for (int step = 0; step < NP; step++) begin
            int expp;
            int got;
            expp = int'(r[step*2 +: 2]);
            #1;
            seen = gnt;
            got = -1;
            for (int q = 0; q < NP; q++) if (gnt[q]) got = q;
            check(seen == NP'(1 << expp), "R4 R2 grant order", 32'(seen), 32'(1 << expp));
            @(negedge clk);
            check(rvalid == seen, "R5 R7 rvalid port", 32'(rvalid), 32'(seen));
            if (got >= 0) begin
                check(rdata == refm[16 + got], "R5 ranked read data", 32'(rdata), 32'(refm[16 + got]));
                req[got] = 1'b0;
            end else begin
                req = '0;
            end
        end
        #1;
        check(gnt == '0, "R2 no grant when idle", 32'(gnt), 0);
    endtask

    task automatic t_stride();
        load_rank(8'b11_10_01_00);
        configure(1, 2'd1, AW'(100), AW'(3), AW'(0));
        @(negedge clk);
        set_port(0, 1'b1, 1'b1, AW'(300), 16'hBEEF);
        set_port(1, 1'b1, 1'b1, AW'(7), 16'h5000);
        #1;
        check(gnt == 4'b0001, "R7 port1 waits", 32'(gnt), 1);
        @(negedge clk);
        req[0] = 1'b0;
        refm[300] = 16'hBEEF;
        #1;
        check(gnt == 4'b0010, "R7 port1 served next", 32'(gnt), 2);
        @(negedge clk);
        req[1] = 1'b0;
        refm[100] = 16'h5000;
        single(1, 1'b1, AW'(7), 16'h5001, AW'(103), "R8 stride write");
        single(1, 1'b1, AW'(7), 16'h5002, AW'(106), "R8 stride write");
        single(0, 1'b0, AW'(100), 0, AW'(100), "R7 R8 stride first slot");
        single(0, 1'b0, AW'(103), 0, AW'(103), "R8 stride second slot");
        single(0, 1'b0, AW'(106), 0, AW'(106), "R8 stride third slot");
        single(0, 1'b0, AW'(300), 0, AW'(300), "R3 waiting write");
        configure(1, 2'd1, AW'(2046), AW'(3), AW'(0));
        single(1, 1'b1, AW'(9), 16'h6000, AW'(2046), "R10 reload base");
        single(1, 1'b1, AW'(9), 16'h6001, AW'(1), "R8 stride wraps modulo");
        single(0, 1'b0, AW'(2046), 0, AW'(2046), "R10 readback");
        single(0, 1'b0, AW'(1), 0, AW'(1), "R8 wrap readback");
    endtask

    task automatic t_circ();
        configure(2, 2'd2, AW'(200), AW'(2), AW'(205));
        single(2, 1'b1, 0, 16'h7000, AW'(200), "R9 circ write");
        single(2, 1'b1, 0, 16'h7001, AW'(202), "R9 circ write");
        single(2, 1'b1, 0, 16'h7002, AW'(204), "R9 circ write");
        single(2, 1'b1, 0, 16'h7003, AW'(206), "R9 circ overshoot");
        single(2, 1'b1, 0, 16'h7004, AW'(200), "R9 circ wrap");
        single(0, 1'b0, AW'(200), 0, AW'(200), "R9 wrapped slot");
        single(0, 1'b0, AW'(206), 0, AW'(206), "R9 overshoot slot");
        configure(2, 2'd2, AW'(200), AW'(2), AW'(205));
        single(2, 1'b0, 0, 0, AW'(200), "R10 circ read restart");
        single(2, 1'b0, 0, 0, AW'(202), "R9 circ read");
        configure(3, 2'd3, AW'(500), AW'(1), AW'(0));
        single(3, 1'b1, AW'(600), 16'h8888, AW'(600), "R6 mode3 direct");
        single(3, 1'b0, AW'(600), 0, AW'(600), "R6 mode3 read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_direct();
        prio_round(8'b11_10_01_00);
        prio_round(8'b00_01_10_11);
        prio_round(8'b01_11_00_10);
        prio_round(8'b10_00_11_01);
        t_stride();
        t_circ();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule